// File: doc/BRIEF.md
# External Interrupt Trigger and Flag Unit

This block conditions a small set of external interrupt request pins for a microcontroller core. Each pin first passes through a two-flop synchroniser. A per-pin trigger-type bit chooses between level and edge sensing, and a per-pin polarity bit chooses whether the active condition is low or high (level mode) or falling or rising (edge mode). Each pin owns one request flag, which is built as a two-state machine per channel with the states `FLG_IDLE` and `FLG_PEND`.

In edge mode the flag latches on the selected transition. Software can set or clear it, and it clears itself when the core acknowledges that source. In level mode the flag is never latched. On every clock it follows the synchronised active level, so acknowledges and software flag writes have no effect in that mode. A request leaves the block only when the pin's own enable and the global enable are both set. When several requests are present, the index of the lowest-numbered pending source is reported. The core returns that index along with its acknowledge.

The flag machine has five named transitions. `LEVEL_FOLLOW` (level mode) loads `FLG_PEND` when the pin is active and `FLG_IDLE` when it is not. `EDGE_SET` goes from `FLG_IDLE` to `FLG_PEND` on a detected edge. `SW_SET` goes from `FLG_IDLE` to `FLG_PEND` on a write of 1. `SW_CLR` goes from `FLG_PEND` to `FLG_IDLE` on a write of 0. `ACK_CLR` goes from `FLG_PEND` to `FLG_IDLE` on a matching acknowledge. `EDGE_SET` outranks `SW_CLR` and `ACK_CLR`, and `SW_CLR` or `SW_SET` outranks `ACK_CLR`.

Top module: `ext_irq_unit`

## Requirements
- R1: After reset, every trigger-type, polarity, enable and flag bit reads 0, and no request output is asserted while the pins are held high.
- R2: With type 0 and polarity 0, a pin's flag is 1 exactly while the pin is low. The flag reflects the pin value present before a rising clock edge, two rising edges later.
- R3: With type 1 and polarity 0, a high-to-low pin transition sets the flag two rising edges after the first edge that samples the low value. The flag stays set when the pin returns high.
- R4: With polarity 1, type 0 gives a flag that follows a high pin level, and type 1 sets the flag on a low-to-high transition, with the same latency as R2 and R3.
- R5: In edge mode, an acknowledge with ack_id equal to i clears flag i on the next edge and leaves every other flag unchanged.
- R6: In level mode, neither an acknowledge nor a software write to the flag bit changes the flag.
- R7: In edge mode, a control-register write loads the flag bit directly on the next edge.
- R8: In edge mode, a detected edge sets the flag even when a software clear or an acknowledge for the same source falls in the same cycle.
- R9: Changing the type or polarity bit while the pin is stable never sets an edge-mode flag.
- R10: irq_req[i] is 1 exactly when flag i, enable i and the global enable are all 1, and irq_any is the OR of irq_req.
- R11: irq_src gives the lowest index i with irq_req[i] set, so pin 0 takes priority over pin 1. It is 0 when nothing is requested.
- R12: Register map (reg_sel). 0 is the control register, with type i at bit 2i and flag i at bit 2i+1. 1 is the enable register, with enable i at bit 2i and the global enable at bit 7. 2 is the polarity register, with polarity i at bit i. Unmapped bits and selector 3 read 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ext_pin | input | NUM_SRC | Asynchronous external interrupt pins |
| reg_wr | input | 1 | Register write strobe |
| reg_sel | input | 2 | Register selector (0 control, 1 enable, 2 polarity) |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data for the selected register |
| ack | input | 1 | Core acknowledge of a serviced interrupt |
| ack_id | input | IDW | Source index being acknowledged |
| irq_req | output | NUM_SRC | Gated request per source |
| irq_any | output | 1 | Any request pending |
| irq_src | output | IDW | Index of the highest-priority pending request |

## Verification
In edge mode, three things can reach the same flag in the same cycle: a hardware edge detection, a software clear through the control register, and a core acknowledge. The bench times a pin transition so that its detection cycle lines up with an acknowledge, and in a second case with a write of 0 to the flag. A behavioural model applies the stated precedence (edge, then write, then acknowledge). Every read value and request output is compared with that model on each clock.

// File: rtl/eirq_pkg.sv
package eirq_pkg;

    typedef enum logic {
        FLG_IDLE = 1'b0,
        FLG_PEND = 1'b1
    } flag_state_e;

    typedef enum logic [1:0] {
        SEL_CTL = 2'd0,
        SEL_EN  = 2'd1,
        SEL_POL = 2'd2,
        SEL_NONE = 2'd3
    } reg_sel_e;

    localparam int REG_W   = 8;
    localparam int GIE_BIT = 7;

endpackage

// File: rtl/eirq_sync.sv
module eirq_sync #(
    parameter int   STAGES  = 2,
    parameter logic RST_VAL = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic dout
);

    logic [STAGES-1:0] chain_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            chain_q <= {STAGES{RST_VAL}};
        end else begin
            chain_q <= {chain_q[STAGES-2:0], din};
        end
    end

    assign dout = chain_q[STAGES-1];

endmodule

// File: rtl/eirq_chan.sv
module eirq_chan
    import eirq_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic pin_s,
    input  logic edge_mode,
    input  logic pol_high,
    input  logic sw_wr,
    input  logic sw_val,
    input  logic ack_hit,
    output logic flag
);

    flag_state_e state_q, state_d;
    logic        hist_q;
    logic        active;
    logic        edge_det;

    // History keeps the raw synchronised pin; polarity applies only in the compare.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hist_q <= 1'b1;
        end else begin
            hist_q <= pin_s;
        end
    end

    always_comb begin
        active   = pol_high ? pin_s : ~pin_s;
        edge_det = pol_high ? (pin_s & ~hist_q) : (~pin_s & hist_q);
    end

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= FLG_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Next state: LEVEL_FOLLOW, EDGE_SET, SW_SET, SW_CLR, ACK_CLR
    always_comb begin
        state_d = state_q;
        if (!edge_mode) begin
            state_d = active ? FLG_PEND : FLG_IDLE;
        end else begin
            unique case (state_q)
                FLG_IDLE: begin
                    if (edge_det || (sw_wr && sw_val)) begin
                        state_d = FLG_PEND;
                    end
                end
                FLG_PEND: begin
                    if (!edge_det) begin
                        if (sw_wr) begin
                            state_d = sw_val ? FLG_PEND : FLG_IDLE;
                        end else if (ack_hit) begin
                            state_d = FLG_IDLE;
                        end
                    end
                end
                default: state_d = FLG_IDLE;
            endcase
        end
    end

    // Output
    always_comb begin
        flag = (state_q == FLG_PEND);
    end

    assert_level_follow_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !edge_mode |=> (flag == $past(active)));

    assert_ack_clear_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (edge_mode && flag && ack_hit && !sw_wr && !edge_det) |=> !flag);

    assert_hw_wins_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (edge_mode && edge_det) |=> flag);

    assert_no_false_edge_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (edge_mode && $stable(pin_s) && !flag && !sw_wr) |=> !flag);

endmodule

// File: rtl/ext_irq_unit.sv
module ext_irq_unit
    import eirq_pkg::*;
#(
    parameter int  NUM_SRC     = 2,
    parameter int  SYNC_STAGES = 2,
    localparam int IDW         = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_SRC-1:0] ext_pin,
    input  logic               reg_wr,
    input  logic [1:0]         reg_sel,
    input  logic [REG_W-1:0]   reg_wdata,
    output logic [REG_W-1:0]   reg_rdata,
    input  logic               ack,
    input  logic [IDW-1:0]     ack_id,
    output logic [NUM_SRC-1:0] irq_req,
    output logic               irq_any,
    output logic [IDW-1:0]     irq_src
);

    logic [NUM_SRC-1:0] type_q;
    logic [NUM_SRC-1:0] pol_q;
    logic [NUM_SRC-1:0] en_q;
    logic               gie_q;
    logic [NUM_SRC-1:0] flag;
    logic [NUM_SRC-1:0] pin_s;
    logic               wr_ctl, wr_en, wr_pol;

    assign wr_ctl = reg_wr && (reg_sel == SEL_CTL);
    assign wr_en  = reg_wr && (reg_sel == SEL_EN);
    assign wr_pol = reg_wr && (reg_sel == SEL_POL);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            type_q <= '0;
            pol_q  <= '0;
            en_q   <= '0;
            gie_q  <= 1'b0;
        end else begin
            for (int i = 0; i < NUM_SRC; i++) begin
                if (wr_ctl) type_q[i] <= reg_wdata[2*i];
                if (wr_en)  en_q[i]   <= reg_wdata[2*i];
                if (wr_pol) pol_q[i]  <= reg_wdata[i];
            end
            if (wr_en) gie_q <= reg_wdata[GIE_BIT];
        end
    end

    for (genvar g = 0; g < NUM_SRC; g++) begin : g_src
        eirq_sync #(
            .STAGES  (SYNC_STAGES),
            .RST_VAL (1'b1)
        ) u_sync (
            .clk   (clk),
            .rst_n (rst_n),
            .din   (ext_pin[g]),
            .dout  (pin_s[g])
        );

        eirq_chan u_chan (
            .clk       (clk),
            .rst_n     (rst_n),
            .pin_s     (pin_s[g]),
            .edge_mode (type_q[g]),
            .pol_high  (pol_q[g]),
            .sw_wr     (wr_ctl),
            .sw_val    (reg_wdata[2*g+1]),
            .ack_hit   (ack && (ack_id == IDW'(g))),
            .flag      (flag[g])
        );
    end

    always_comb begin
        irq_req = flag & en_q & {NUM_SRC{gie_q}};
        irq_any = |irq_req;
        irq_src = '0;
        for (int i = NUM_SRC - 1; i >= 0; i--) begin
            if (irq_req[i]) irq_src = IDW'(i);
        end
    end

    always_comb begin
        reg_rdata = '0;
        unique case (reg_sel)
            SEL_CTL: begin
                for (int i = 0; i < NUM_SRC; i++) begin
                    reg_rdata[2*i]   = type_q[i];
                    reg_rdata[2*i+1] = flag[i];
                end
            end
            SEL_EN: begin
                for (int i = 0; i < NUM_SRC; i++) reg_rdata[2*i] = en_q[i];
                reg_rdata[GIE_BIT] = gie_q;
            end
            SEL_POL: begin
                for (int i = 0; i < NUM_SRC; i++) reg_rdata[i] = pol_q[i];
            end
            default: reg_rdata = '0;
        endcase
    end

    assert_gate_R10: assert property (@(posedge clk) disable iff (!rst_n)
        irq_any |-> (gie_q && ((flag & en_q) != '0)));

    assert_prio_R11: assert property (@(posedge clk) disable iff (!rst_n)
        irq_req[0] |-> (irq_src == '0));

    assert_reset_R1: assert property (@(posedge clk)
        !rst_n |=> (irq_req == '0));

endmodule

// File: tb/ext_irq_unit_tb.sv
`timescale 1ns/1ps
module ext_irq_unit_tb;

    localparam int N = 2;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [1:0] ext_pin = 2'b11;
    logic       reg_wr = 1'b0;
    logic [1:0] reg_sel = 2'd0;
    logic [7:0] reg_wdata = 8'h00;
    logic [7:0] reg_rdata;
    logic       ack = 1'b0;
    logic [0:0] ack_id = 1'b0;
    logic [1:0] irq_req;
    logic       irq_any;
    logic [0:0] irq_src;

    int    checks = 0;
    int    fails  = 0;
    bit    done   = 1'b0;
    string cur_req = "R1";

    always #2.5 clk = ~clk;

    ext_irq_unit u_dut (
        .clk, .rst_n, .ext_pin, .reg_wr, .reg_sel, .reg_wdata, .reg_rdata,
        .ack, .ack_id, .irq_req, .irq_any, .irq_src
    );

    // Behavioural reference: queue of sampled pin vectors, newest first
    logic [1:0] pq[$];
    logic [1:0] m_type, m_pol, m_en, m_flag;
    logic       m_gie;
    logic [1:0] s2, hh;

    always @(posedge clk) begin
        if (!rst_n) begin
            pq = {2'b11, 2'b11, 2'b11};
            m_type = 0; m_pol = 0; m_en = 0; m_flag = 0; m_gie = 0;
        end else begin
            s2 = pq[1];
            hh = pq[2];
            for (int i = 0; i < N; i++) begin
                bit act, edg;
                act = m_pol[i] ? s2[i] : !s2[i];
                edg = m_pol[i] ? (s2[i] && !hh[i]) : (!s2[i] && hh[i]);
                if (!m_type[i]) m_flag[i] = act;
                else if (edg) m_flag[i] = 1'b1;
                else if (reg_wr && reg_sel == 2'd0) m_flag[i] = reg_wdata[2*i+1];
                else if (ack && ack_id == i) m_flag[i] = 1'b0;
            end
            if (reg_wr && reg_sel == 2'd0) begin
                m_type[0] = reg_wdata[0]; m_type[1] = reg_wdata[2];
            end
            if (reg_wr && reg_sel == 2'd1) begin
                m_en[0] = reg_wdata[0]; m_en[1] = reg_wdata[2]; m_gie = reg_wdata[7];
            end
            if (reg_wr && reg_sel == 2'd2) m_pol = reg_wdata[1:0];
            pq.push_front(ext_pin);
            void'(pq.pop_back());
        end
    end

    function automatic logic [7:0] exp_rd(logic [1:0] sel);
        case (sel)
            2'd0: return {4'b0, m_flag[1], m_type[1], m_flag[0], m_type[0]};
            2'd1: return {m_gie, 4'b0, m_en[1], 1'b0, m_en[0]};
            2'd2: return {6'b0, m_pol};
            default: return 8'h00;
        endcase
    endfunction

    task automatic check(string what, logic [7:0] act, logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s: actual %h expected %h at %0t", cur_req, what, act, exp, $time);
        end
    endtask

    // Compare every cycle, away from the active edge
    always @(negedge clk) begin
        if (rst_n && !done) begin
            logic [1:0] rq;
            logic [0:0] sr;
            rq = m_flag & m_en & {2{m_gie}};
            sr = (rq[0] || !rq[1]) ? 1'b0 : 1'b1;
            check("rdata", reg_rdata, exp_rd(reg_sel));
            check("irq_req", {6'b0, irq_req}, {6'b0, rq});      // R10
            check("irq_any", {7'b0, irq_any}, {7'b0, |rq});     // R10
            check("irq_src", {7'b0, irq_src}, {7'b0, sr});      // R11
        end
    end

    task automatic cyc(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr(logic [1:0] sel, logic [7:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_sel = sel; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0; reg_sel = 2'd0;
    endtask

    task automatic do_ack(logic id);
        @(negedge clk);
        ack = 1'b1; ack_id = id;
        @(negedge clk);
        ack = 1'b0;
    endtask

    task automatic rd_all();
        for (int s = 0; s < 4; s++) begin
            @(negedge clk);
            reg_sel = 2'(s);
        end
        @(negedge clk);
        reg_sel = 2'd0;
    endtask

    initial begin
        cyc(3);
        rst_n = 1'b1;

        cur_req = "R1";  rd_all(); cyc(3);

        cur_req = "R12"; wr(2'd1, 8'hFF); rd_all(); wr(2'd2, 8'hFF); rd_all();
        wr(2'd2, 8'h00); wr(2'd1, 8'h85); rd_all();

        cur_req = "R2";  ext_pin[0] = 1'b0; cyc(5); ext_pin[0] = 1'b1; cyc(5);
        ext_pin[1] = 1'b0; cyc(2); ext_pin[1] = 1'b1; cyc(4);

        cur_req = "R3";  wr(2'd0, 8'h05); cyc(3);
        ext_pin[0] = 1'b0; cyc(4); ext_pin[0] = 1'b1; cyc(4);

        cur_req = "R5";  ext_pin[1] = 1'b0; cyc(4); ext_pin[1] = 1'b1; cyc(2);
        do_ack(1'b1); cyc(2); do_ack(1'b0); cyc(2);

        cur_req = "R4";  wr(2'd2, 8'h03); cyc(3);
        ext_pin[0] = 1'b0; cyc(3); ext_pin[0] = 1'b1; cyc(4);
        wr(2'd0, 8'h04); cyc(3); ext_pin[0] = 1'b0; cyc(4); ext_pin[0] = 1'b1; cyc(4);

        cur_req = "R6";  do_ack(1'b0); wr(2'd0, 8'h06); cyc(3); do_ack(1'b0); cyc(2);
        wr(2'd2, 8'h00); wr(2'd0, 8'h07); cyc(3);

        cur_req = "R7";  wr(2'd0, 8'h0F); cyc(2); wr(2'd0, 8'h05); cyc(2);
        wr(2'd0, 8'h07); cyc(2);

        cur_req = "R11"; wr(2'd0, 8'h0F); cyc(2); wr(2'd1, 8'h84); cyc(2);
        wr(2'd1, 8'h05); cyc(2); wr(2'd1, 8'h85); do_ack(1'b0); cyc(2); do_ack(1'b1); cyc(2);

        cur_req = "R8";
        @(negedge clk); ext_pin[0] = 1'b0;
        @(negedge clk); @(negedge clk); ack = 1'b1; ack_id = 1'b0;
        @(negedge clk); ack = 1'b0; cyc(2);
        ext_pin[0] = 1'b1; cyc(4); do_ack(1'b0); cyc(2);
        @(negedge clk); ext_pin[1] = 1'b0;
        @(negedge clk);
        @(negedge clk); reg_wr = 1'b1; reg_sel = 2'd0; reg_wdata = 8'h05;
        @(negedge clk); reg_wr = 1'b0; cyc(3); ext_pin[1] = 1'b1; cyc(4);

        cur_req = "R9";  wr(2'd0, 8'h05); cyc(2); wr(2'd2, 8'h03); cyc(4);
        wr(2'd2, 8'h00); cyc(4); wr(2'd0, 8'h00); cyc(2); wr(2'd0, 8'h05); cyc(4);

        cur_req = "R10"; wr(2'd0, 8'h0F); wr(2'd1, 8'h05); cyc(2); wr(2'd1, 8'h80); cyc(2);
        wr(2'd1, 8'h84); cyc(2);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

endmodule